// File: doc/BRIEF.md
# Nanosecond Time-of-Day Clock

This block keeps a free-running 64-bit count of nanoseconds for a network port. A 32-bit fraction sits below it. On every cycle where the fixed-rate `tick` input is high, the block adds an increment to the combined `{nanoseconds, fraction}` value. The increment is in 32.32 fixed point. It is a programmable base increment multiplied by a factor taken from the current link speed. The running time drives `time_ns`, which goes to the timestamp units.

Software reaches the block through a simple 32-bit register port. It can set or read the time and the base increment as low and high halves, and it can enable or stop counting.

- **Reads are coherent.** Reading the low time half captures the upper half into a shadow register. The next high-half read returns that captured value.
- **Writes are staged.** A low-half write is held in a staging register, and nothing changes until the matching high half is written.

The clock holds still when counting is disabled or when the link runs at the unsupported slowest rate.

Top module: `ns_tod_clock`

## Requirements
- R1: Reset clears the time, the fraction and the enable bit, and sets the base increment to 0x1_9999_9999 (1.6 ns per tick, 32 fractional bits). Reads return 0x99999999 from the increment low half and 0x00000001 from the increment high half.
- R2: Register addresses are 0 for control (bit 0 is the count enable), 1 and 2 for the time low and high halves, and 3 and 4 for the increment low and high halves. `reg_rdata` carries the value in the cycle after a `reg_re` cycle. The value is taken from the state before that clock edge.
- R3: In each cycle with `tick` high and counting enabled, `{time_ns, fraction}` grows by the effective increment, wrapping modulo 2^96. A carry out of the fraction moves into the nanosecond count.
- R4: The effective increment is the base increment times a factor chosen by `speed_code`: 1 for code 0 (top rate or no link), 2 for code 1, and 20 for code 2.
- R5: `speed_code` 3 gives a factor of 0, so the time holds even while enabled and ticking.
- R6: The time and fraction hold in any cycle where `tick` is low or the enable bit is clear.
- R7: A time low-half write only stages its data. A time high-half write loads {high, staged low} into the counter at that edge and clears the fraction. A load in the same cycle as a tick takes priority, and the loaded value advances from the next tick.
- R8: An increment low-half write only stages its data. The base increment becomes {high, staged low} when the high half is written, and read-back returns the active increment.
- R9: A time low-half read returns the current low half and captures the current high half. A later time high-half read returns the captured half, even if the counter has carried since.
- R10: Writes to addresses 5 to 7 change no state, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Fixed-rate advance strobe |
| speed_code | input | 2 | Link speed selector (0 top/no link, 1 x2, 2 x20, 3 stop) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_re` |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
Directed runs come first:
- ten ticks at the base rate, which must give 15 ns and not 16, showing that the fraction truncates;
- each speed code in turn, to separate the x1, x2, x20 and stop factors;
- staged low-half writes followed by high-half commits, and a load that lands on a tick;
- a low-half read placed just before a carry into the upper word, which exposes a missing snapshot.

A long random phase then mixes sparse ticks, enable toggles, speed changes, time and increment writes (including wrapping values), reads and unmapped writes. A reference model in the bench compares the time every cycle and the read data after every read, which exposes ordering faults between loads, ticks and staging.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned NS_W   = 64;
  localparam int unsigned FR_W   = 32;
  localparam int unsigned INC_W  = 64;
  localparam int unsigned MULT_W = 5;
  localparam int unsigned ACC_W  = NS_W + FR_W;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_TLO  = 3'd1,
    RA_THI  = 3'd2,
    RA_ILO  = 3'd3,
    RA_IHI  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SPD_TOP = 2'd0,
    SPD_MID = 2'd1,
    SPD_LOW = 2'd2,
    SPD_OFF = 2'd3
  } speed_e;

  // Speed code to increment multiplier
  function automatic logic [MULT_W-1:0] speed_mult(input logic [1:0] code);
    case (speed_e'(code))
      SPD_TOP: speed_mult = MULT_W'(1);
      SPD_MID: speed_mult = MULT_W'(2);
      SPD_LOW: speed_mult = MULT_W'(20);
      default: speed_mult = '0;
    endcase
  endfunction

  // One accumulation step of {ns, frac} by a 32.32 increment
  function automatic logic [ACC_W-1:0] accum(input logic [ACC_W-1:0] acc,
                                             input logic [INC_W-1:0] inc);
    accum = acc + {{(ACC_W-INC_W){1'b0}}, inc};
  endfunction

endpackage

// File: rtl/ptpc_regs.sv
module ptpc_regs
  import ptpc_pkg::*;
#(
  parameter logic [INC_W-1:0] BASE_INC = 64'h0000_0001_9999_9999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NS_W-1:0]   cur_ns,
  output logic [REG_W-1:0]  rdata,
  output logic              count_en,
  output logic [INC_W-1:0]  inc_base,
  output logic              time_load,
  output logic [NS_W-1:0]   load_val
);

  localparam int unsigned HI_LSB = NS_W - REG_W;

  logic [REG_W-1:0] time_stage;
  logic [REG_W-1:0] inc_stage;
  logic [REG_W-1:0] snap_hi;

  // Commit events, named for the checks
  logic wr_tlo, wr_ilo, wr_ihi, rd_tlo;
  assign wr_tlo    = we && (reg_addr_e'(addr) == RA_TLO);
  assign wr_ilo    = we && (reg_addr_e'(addr) == RA_ILO);
  assign wr_ihi    = we && (reg_addr_e'(addr) == RA_IHI);
  assign rd_tlo    = re && (reg_addr_e'(addr) == RA_TLO);
  assign time_load = we && (reg_addr_e'(addr) == RA_THI);
  assign load_val  = {wdata, time_stage};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_en   <= 1'b0;
      inc_base   <= BASE_INC;
      time_stage <= '0;
      inc_stage  <= '0;
      snap_hi    <= '0;
      rdata      <= '0;
    end else begin
      if (we) begin
        case (reg_addr_e'(addr))
          RA_CTRL: count_en   <= wdata[0];
          RA_TLO:  time_stage <= wdata;
          RA_ILO:  inc_stage  <= wdata;
          RA_IHI:  inc_base   <= {wdata, inc_stage};
          default: ;
        endcase
      end
      if (re) begin
        case (reg_addr_e'(addr))
          RA_CTRL: rdata <= {{(REG_W-1){1'b0}}, count_en};
          RA_TLO: begin
            rdata   <= cur_ns[REG_W-1:0];
            snap_hi <= cur_ns[NS_W-1:HI_LSB];
          end
          RA_THI:  rdata <= snap_hi;
          RA_ILO:  rdata <= inc_base[REG_W-1:0];
          RA_IHI:  rdata <= inc_base[INC_W-1:REG_W];
          default: rdata <= '0;
        endcase
      end
    end
  end

  a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tlo |=> snap_hi == $past(cur_ns[NS_W-1:HI_LSB]));

  a_r8_inc_staged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ilo && !wr_ihi) |=> $stable(inc_base));

  a_r8_inc_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ihi |=> inc_base[INC_W-1:REG_W] == $past(wdata));

  a_r7_no_load_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tlo |-> !time_load);

endmodule

// File: rtl/ptpc_rate.sv
module ptpc_rate
  import ptpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             count_en,
  input  logic [1:0]       speed_code,
  input  logic [INC_W-1:0] inc_base,
  output logic [INC_W-1:0] eff_inc,
  output logic             advance
);

  logic [MULT_W-1:0] mult;

  assign mult    = speed_mult(speed_code);
  assign eff_inc = inc_base * {{(INC_W-MULT_W){1'b0}}, mult};
  assign advance = tick && count_en && (mult != '0);

  a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_e'(speed_code) == SPD_OFF) |-> !advance);

  a_r4_double: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_e'(speed_code) == SPD_MID) |-> eff_inc == (inc_base << 1));

  a_r4_twenty: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_e'(speed_code) == SPD_LOW) |-> eff_inc == ((inc_base << 4) + (inc_base << 2)));

  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick || !count_en) |-> !advance);

endmodule

// File: rtl/ptpc_counter.sv
module ptpc_counter
  import ptpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [INC_W-1:0] eff_inc,
  input  logic             load,
  input  logic [NS_W-1:0]  load_val,
  output logic [NS_W-1:0]  ns
);

  logic [ACC_W-1:0] acc;
  logic [FR_W-1:0]  frac;

  assign ns   = acc[ACC_W-1:FR_W];
  assign frac = acc[FR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (load)    acc <= {load_val, {FR_W{1'b0}}};
    else if (advance) acc <= accum(acc, eff_inc);
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> ($stable(ns) && $stable(frac)));

  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ns == $past(load_val) && frac == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && eff_inc[INC_W-1:FR_W] != '0 && ns < 64'hFFFF_0000_0000_0000) |=> ns > $past(ns));

endmodule

// File: rtl/ns_tod_clock.sv
module ns_tod_clock
  import ptpc_pkg::*;
#(
  parameter logic [63:0] BASE_INC = 64'h0000_0001_9999_9999
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  speed_code,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] time_ns
);

  logic             count_en;
  logic [INC_W-1:0] inc_base;
  logic [INC_W-1:0] eff_inc;
  logic             advance;
  logic             time_load;
  logic [NS_W-1:0]  load_val;

  ptpc_regs #(.BASE_INC(BASE_INC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .re        (reg_re),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .cur_ns    (time_ns),
    .rdata     (reg_rdata),
    .count_en  (count_en),
    .inc_base  (inc_base),
    .time_load (time_load),
    .load_val  (load_val)
  );

  ptpc_rate u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .count_en   (count_en),
    .speed_code (speed_code),
    .inc_base   (inc_base),
    .eff_inc    (eff_inc),
    .advance    (advance)
  );

  ptpc_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .eff_inc  (eff_inc),
    .load     (time_load),
    .load_val (load_val),
    .ns       (time_ns)
  );

  a_r1_reset_inc: assert property (@(posedge clk)
    !rst_n |=> inc_base == BASE_INC && !count_en && time_ns == '0);

endmodule

// File: tb/ns_tod_clock_bench.sv
`timescale 1ns/1ps
module ns_tod_clock_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  speed_code = 2'd0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [63:0] time_ns;

  always #2.5 clk = ~clk;

  ns_tod_clock u_ns_tod_clock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .speed_code(speed_code),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  // Reference state
  logic [95:0] m_acc;
  logic        m_en;
  logic [63:0] m_inc;
  logic [31:0] m_tstage, m_istage, m_snap;

  function automatic logic [63:0] ref_eff(input logic [1:0] spd, input logic [63:0] b);
    case (spd)
      2'd0: ref_eff = b;
      2'd1: ref_eff = b + b;
      2'd2: ref_eff = (b << 4) + (b << 2);
      default: ref_eff = 64'd0;
    endcase
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_en = 1'b0; m_inc = 64'h1_9999_9999;
    m_tstage = '0; m_istage = '0; m_snap = '0;
  endtask

  // One clock with given stimulus; updates model and checks outputs
  task automatic cyc(input bit tk, input bit we, input bit re,
                     input logic [2:0] a, input logic [31:0] d);
    logic [31:0] exp_rd;
    logic [95:0] nxt;
    @(negedge clk);
    tick = tk; reg_we = we; reg_re = re; reg_addr = a; reg_wdata = d;
    exp_rd = 32'd0;
    case (a)
      3'd0: exp_rd = {31'd0, m_en};
      3'd1: exp_rd = m_acc[63:32];
      3'd2: exp_rd = m_snap;
      3'd3: exp_rd = m_inc[31:0];
      3'd4: exp_rd = m_inc[63:32];
      default: exp_rd = 32'd0;
    endcase
    nxt = m_acc;
    if (we && a == 3'd2) nxt = {d, m_tstage, 32'd0};
    else if (tk && m_en && speed_code != 2'd3)
      nxt = m_acc + {32'd0, ref_eff(speed_code, m_inc)};
    if (re && a == 3'd1) m_snap = m_acc[95:64];
    if (we) begin
      case (a)
        3'd0: m_en = d[0];
        3'd1: m_tstage = d;
        3'd3: m_istage = d;
        3'd4: m_inc = {d, m_istage};
        default: ;
      endcase
    end
    m_acc = nxt;
    @(posedge clk);
    #1;
    chk(cur_req, time_ns, m_acc[95:32]);
    if (re) chk(cur_req, {32'd0, reg_rdata}, {32'd0, exp_rd});
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) cyc(tk, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(1'b0, 1'b0, 1'b1, a, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd1588);
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0;
    // R1: reset state
    cur_req = "R1";
    chk("R1", time_ns, 64'd0);
    rd(3'd0); rd(3'd3); rd(3'd4);
    chk("R1", {32'd0, reg_rdata}, 64'h1);

    // R6: disabled clock holds with ticks
    cur_req = "R6";
    idle(5, 1'b1);
    chk("R6", time_ns, 64'd0);

    // R3: ten base ticks truncate to 15 ns
    cur_req = "R3";
    wr(3'd0, 32'd1);
    idle(10, 1'b1);
    chk("R3", time_ns, 64'd15);
    cur_req = "R6";
    idle(4, 1'b0);
    chk("R6", time_ns, 64'd15);

    // R4: speed factors
    cur_req = "R4";
    speed_code = 2'd1; idle(7, 1'b1);
    speed_code = 2'd2; idle(7, 1'b1);
    speed_code = 2'd0; idle(3, 1'b1);

    // R5: stop code
    cur_req = "R5";
    speed_code = 2'd3;
    idle(6, 1'b1);
    chk("R5", time_ns, m_acc[95:32]);
    speed_code = 2'd0;

    // R7: staged load, then load colliding with tick
    cur_req = "R7";
    wr(3'd1, 32'h1234_5678);
    idle(3, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 3'd2, 32'h0000_00AB);
    chk("R7", time_ns, 64'h0000_00AB_1234_5678);
    idle(1, 1'b1);

    // R8: increment staging and commit
    cur_req = "R8";
    wr(3'd3, 32'd0);
    idle(2, 1'b1);
    rd(3'd3);
    wr(3'd4, 32'd2);
    rd(3'd3); rd(3'd4);
    chk("R8", {32'd0, reg_rdata}, 64'd2);

    // R9: snapshot survives a carry into the upper half
    cur_req = "R9";
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'd5);
    rd(3'd1);
    idle(12, 1'b1);
    rd(3'd2);
    chk("R9", {32'd0, reg_rdata}, 64'd5);
    chk("R9", time_ns >> 32, 64'd6);

    // R10: unmapped addresses
    cur_req = "R10";
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd0); rd(3'd3); rd(3'd4); rd(3'd6);
    chk("R10", {32'd0, reg_rdata}, 64'd0);

    // R2: random mix against the reference
    cur_req = "R2";
    wr(3'd4, 32'd1); // restore a sane base
    for (int n = 0; n < 6000; n++) begin
      int unsigned op;
      bit tk;
      tk = ($urandom % 4) != 0;
      if (n % 97 == 0) speed_code = 2'($urandom % 4);
      op = $urandom % 16;
      case (op)
        0: cyc(tk, 1'b1, 1'b0, 3'd0, {31'd0, 1'(($urandom % 5) != 0)});
        1: cyc(tk, 1'b1, 1'b0, 3'd1, $urandom);
        2: cyc(tk, 1'b1, 1'b0, 3'd2, (n % 7 == 0) ? 32'hFFFF_FFFF : $urandom);
        3: cyc(tk, 1'b1, 1'b0, 3'd3, $urandom);
        4: cyc(tk, 1'b1, 1'b0, 3'd4, $urandom % 4);
        5, 6, 7: cyc(tk, 1'b0, 1'b1, 3'($urandom % 8), 32'd0);
        8: cyc(tk, 1'b1, 1'b0, 3'(5 + $urandom % 3), $urandom);
        default: cyc(tk, 1'b0, 1'b0, 3'd0, 32'd0);
      endcase
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule